// File: doc/BRIEF.md
# Serial Clock Prescaler with Mantissa-Exponent Divider

This block turns a fast core clock into the serial clock for a synchronous serial shift engine. A prescale field, held in a configuration register elsewhere, selects the divide ratio. The block reports the decoded divider and drives the serial clock level. It also gives a one-cycle strobe on each edge that moves the clock away from its rest level (leading) and on each edge that returns it (trailing). The shift engine launches and captures data on these strobes.

A build-time parameter picks one of two field formats. The compact format has a four-bit mantissa scaled by a power of two. The three exponent bits sit at non-adjacent field positions. This reaches dividers up to 1920. The older format is a five-bit field holding an offset of sixteen plus half the divider, so it gives only even ratios from 4 to 30. Outside a transfer the clock rests at the polarity level and no strobes occur. A transfer start or any change of the field restarts the half-period count.

Top module: `spi_baud_prescaler`

## Requirements
- R1: With the compact format (EXT_ENC=1), field bits [3:0] form the mantissa M, field bit 4 is exponent bit 0 and field bits [7:6] are exponent bits [2:1]. `divider_out` equals M×2^E, with M=0 read as 1, so the largest value is 1920. Field bit 5 has no effect.
- R2: With the older format (EXT_ENC=0), only field bits [4:0] (value F) are used. `divider_out` equals 2×(F−16) when that is at least 4, and 4 otherwise. Bits [7:5] have no effect.
- R3: While `xfer_active` is low, `sck` equals `cpol` and neither strobe is asserted.
- R4: When `xfer_active` is first sampled high at a clock edge, the first leading strobe and the first `sck` change follow exactly one rest-level half period later, in core clocks.
- R5: The generation period is the effective divider D. The high level of `sck` lasts ceil(D/2) core clocks and the low level lasts floor(D/2). The rest-level half is the low half when `cpol`=0 and the high half when `cpol`=1.
- R6: The strobes alternate, and they are never high together. A leading strobe comes in the cycle `sck` first shows the level opposite `cpol`. A trailing strobe comes in the cycle it returns to `cpol`.
- R7: When the field changes during a transfer, the half-period count restarts. No edge is made in the cycle the change is seen, even if the count would have expired there. The next edge follows one full new half period later.
- R8: A decoded divider below 2 is generated as 2: one core clock per level.
- R9: While `rst` is high, both strobes are low and `sck` equals `cpol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| presc_field | input | 8 | Prescale field from the configuration register |
| cpol | input | 1 | Clock rest level |
| xfer_active | input | 1 | High for the duration of a transfer |
| divider_out | output | 11 | Decoded divide ratio |
| sck | output | 1 | Serial clock |
| lead_strobe | output | 1 | One-cycle pulse as sck leaves its rest level |
| trail_strobe | output | 1 | One-cycle pulse as sck returns to its rest level |

## Verification
In one cycle a field change can be seen and the half-period count can also reach its terminal value. The two then compete: one restarts the count, the other toggles the clock. The bench sets this up by starting a transfer with a 3-cycle rest half. It then changes the field on the exact cycle the first edge is due. It checks that no leading strobe occurs in that cycle or the next. The first edge must come one new half period after the change, and both encodings are held to the same outcome.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;

    localparam int FIELD_W     = 8;
    localparam int SPR_W       = 4;
    localparam int EXP_W       = 3;
    localparam int LEG_W       = 5;
    localparam int DIV_W       = SPR_W + (1 << EXP_W) - 1;
    localparam int MAX_EXT_DIV = ((1 << SPR_W) - 1) << ((1 << EXP_W) - 1);
    localparam int LEG_MIN_DIV = 4;
    localparam int LEG_MAX_DIV = 30;
    localparam int MIN_GEN_DIV = 2;

    typedef logic [DIV_W-1:0] div_t;

    typedef struct packed {
        logic [SPR_W-1:0] mant;
        logic [EXP_W-1:0] expo;
    } ext_code_t;

    typedef struct packed {
        div_t rest_len;
        div_t act_len;
    } half_t;

    // Exponent bits are scattered: bit 0 at field[4], bits 2:1 at field[7:6].
    function automatic ext_code_t unpack_ext(input logic [FIELD_W-1:0] f);
        ext_code_t c;
        c.mant = f[3:0];
        c.expo = {f[7:6], f[4]};
        return c;
    endfunction

    function automatic div_t ext_divider(input ext_code_t c);
        div_t m;
        m = (c.mant == '0) ? div_t'(1) : div_t'(c.mant);
        return m << c.expo;
    endfunction

    function automatic div_t legacy_divider(input logic [LEG_W-1:0] f);
        if (f[4] && (f[3:0] >= 4'd2))
            return div_t'({f[3:0], 1'b0});
        return div_t'(LEG_MIN_DIV);
    endfunction

    // High level takes the extra cycle of an odd period.
    function automatic half_t split_period(input div_t d, input logic pol);
        half_t h;
        div_t  eff;
        div_t  hi;
        div_t  lo;
        eff = (d < div_t'(MIN_GEN_DIV)) ? div_t'(MIN_GEN_DIV) : d;
        hi  = (eff + div_t'(1)) >> 1;
        lo  = eff >> 1;
        h.rest_len = pol ? hi : lo;
        h.act_len  = pol ? lo : hi;
        return h;
    endfunction

endpackage

// File: rtl/presc_decode.sv
module presc_decode
    import spi_presc_pkg::*;
#(
    parameter bit EXT_ENC = 1'b1
) (
    input  logic [FIELD_W-1:0] field,
    output div_t               divider
);

    generate
        if (EXT_ENC) begin : g_ext
            logic unused_gap_bit;
            assign unused_gap_bit = field[5];
            always_comb divider = ext_divider(unpack_ext(field));
        end else begin : g_leg
            logic unused_upper;
            assign unused_upper = ^field[FIELD_W-1:LEG_W];
            always_comb divider = legacy_divider(field[LEG_W-1:0]);
        end
    endgenerate

endmodule

// File: rtl/sck_edge_gen.sv
module sck_edge_gen
    import spi_presc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [FIELD_W-1:0] field,
    input  div_t               divider,
    input  logic               cpol,
    input  logic               xfer_active,
    output logic               sck,
    output logic               lead,
    output logic               trail
);

    logic [FIELD_W-1:0] field_q;
    logic               act_q;
    logic               phase_q;
    div_t               cnt_q;
    half_t              halves;
    div_t               cur_len;
    logic               field_chg;
    logic               start;
    logic               restart;
    logic               terminal;

    always_comb begin
        halves    = split_period(divider, cpol);
        cur_len   = phase_q ? halves.act_len : halves.rest_len;
        field_chg = (field != field_q);
        start     = xfer_active && !act_q;
        restart   = field_chg || start;
        terminal  = (cnt_q == cur_len - div_t'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            field_q <= '0;
            act_q   <= 1'b0;
            phase_q <= 1'b0;
            cnt_q   <= '0;
            lead    <= 1'b0;
            trail   <= 1'b0;
        end else begin
            field_q <= field;
            act_q   <= xfer_active;
            lead    <= 1'b0;
            trail   <= 1'b0;
            if (!xfer_active) begin
                cnt_q   <= '0;
                phase_q <= 1'b0;
            end else if (restart) begin
                cnt_q <= '0;
            end else if (terminal) begin
                cnt_q   <= '0;
                phase_q <= !phase_q;
                lead    <= !phase_q;
                trail   <= phase_q;
            end else begin
                cnt_q <= cnt_q + div_t'(1);
            end
        end
    end

    assign sck = cpol ^ phase_q;

    AST_IDLE_REST: assert property (@(posedge clk) disable iff (rst)
        !xfer_active |=> (sck == cpol));                                  // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !xfer_active |=> !(lead || trail));                               // R3
    AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(lead && trail));                                                // R6
    AST_LEAD_DIR: assert property (@(posedge clk) disable iff (rst)
        lead |-> (phase_q && !$past(phase_q)));                           // R6
    AST_TRAIL_DIR: assert property (@(posedge clk) disable iff (rst)
        trail |-> (!phase_q && $past(phase_q)));                          // R6
    AST_RESTART_WINS: assert property (@(posedge clk) disable iff (rst)
        (xfer_active && field_chg) |=> !(lead || trail));                 // R7

endmodule

// File: rtl/spi_baud_prescaler.sv
module spi_baud_prescaler
    import spi_presc_pkg::*;
#(
    parameter bit EXT_ENC = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [FIELD_W-1:0] presc_field,
    input  logic               cpol,
    input  logic               xfer_active,
    output logic [DIV_W-1:0]   divider_out,
    output logic               sck,
    output logic               lead_strobe,
    output logic               trail_strobe
);

    div_t div_w;

    presc_decode #(.EXT_ENC(EXT_ENC)) u_decode (
        .field   (presc_field),
        .divider (div_w)
    );

    sck_edge_gen u_gen (
        .clk         (clk),
        .rst         (rst),
        .field       (presc_field),
        .divider     (div_w),
        .cpol        (cpol),
        .xfer_active (xfer_active),
        .sck         (sck),
        .lead        (lead_strobe),
        .trail       (trail_strobe)
    );

    assign divider_out = div_w;

    generate
        if (EXT_ENC) begin : g_chk_ext
            AST_EXT_DIV_RANGE: assert property (@(posedge clk) disable iff (rst)
                (divider_out >= div_t'(1)) && (divider_out <= div_t'(MAX_EXT_DIV))); // R1
        end else begin : g_chk_leg
            AST_LEG_DIV_RANGE: assert property (@(posedge clk) disable iff (rst)
                !divider_out[0] && (divider_out >= div_t'(LEG_MIN_DIV))
                && (divider_out <= div_t'(LEG_MAX_DIV)));                      // R2
        end
    endgenerate

endmodule

// File: tb/tb_spi_baud_prescaler.sv
module tb_spi_baud_prescaler;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  field = 8'h13;
    logic        cpol = 1'b1;
    logic        xfer = 1'b1;
    logic [10:0] div_e, div_l;
    logic        sck_e, sck_l, lead_e, lead_l, trail_e, trail_l;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    spi_baud_prescaler #(.EXT_ENC(1'b1)) dut (
        .clk(clk), .rst(rst), .presc_field(field), .cpol(cpol), .xfer_active(xfer),
        .divider_out(div_e), .sck(sck_e), .lead_strobe(lead_e), .trail_strobe(trail_e)
    );

    spi_baud_prescaler #(.EXT_ENC(1'b0)) dut_leg (
        .clk(clk), .rst(rst), .presc_field(field), .cpol(cpol), .xfer_active(xfer),
        .divider_out(div_l), .sck(sck_l), .lead_strobe(lead_l), .trail_strobe(trail_l)
    );

    // {field[7:0], compact divider[11:0], older divider[11:0]}
    localparam logic [31:0] VEC [16] = '{
        32'h00_001_004, 32'h01_001_004, 32'h0F_00F_004, 32'h10_002_004,
        32'h13_006_006, 32'h1F_01E_01E, 32'h20_001_004, 32'h2A_00A_004,
        32'h45_014_004, 32'h85_050_004, 32'hC3_0C0_004, 32'hDF_780_01E,
        32'hF9_480_012, 32'h18_010_010, 32'h12_004_004, 32'h11_002_004
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic run_timing(input logic [7:0] f, input logic pol,
                              input int de, input int dl, input string first_req);
        int eff_e, eff_l, rest_e, act_e, rest_l, act_l;
        int fl_e, tr_e, sl_e, fl_l, tr_l, sl_l;
        logic sk_e, sk_l;
        eff_e = (de < 2) ? 2 : de;
        eff_l = (dl < 2) ? 2 : dl;
        rest_e = pol ? (eff_e + 1) / 2 : eff_e / 2;
        act_e  = eff_e - rest_e;
        rest_l = pol ? (eff_l + 1) / 2 : eff_l / 2;
        act_l  = eff_l - rest_l;
        fl_e = -1; tr_e = -1; sl_e = -1; fl_l = -1; tr_l = -1; sl_l = -1;
        sk_e = pol; sk_l = pol;
        @(negedge clk);
        xfer = 1'b0; field = f; cpol = pol;
        repeat (3) @(negedge clk);
        xfer = 1'b1;
        for (int i = 1; i <= 70; i++) begin
            @(negedge clk);
            if (lead_e && fl_e >= 0 && sl_e < 0) sl_e = i;
            if (lead_e && fl_e < 0) begin fl_e = i; sk_e = sck_e; end
            if (trail_e && tr_e < 0) tr_e = i;
            if (lead_l && fl_l >= 0 && sl_l < 0) sl_l = i;
            if (lead_l && fl_l < 0) begin fl_l = i; sk_l = sck_l; end
            if (trail_l && tr_l < 0) tr_l = i;
        end
        xfer = 1'b0;
        chk(fl_e == rest_e + 1, {first_req, " compact first lead"}, fl_e, rest_e + 1);
        chk(fl_l == rest_l + 1, {first_req, " older first lead"}, fl_l, rest_l + 1);
        chk(tr_e == rest_e + act_e + 1, "R5 compact first trail", tr_e, rest_e + act_e + 1);
        chk(tr_l == rest_l + act_l + 1, "R5 older first trail", tr_l, rest_l + act_l + 1);
        chk(sl_e == fl_e + eff_e, "R5 compact period", sl_e - fl_e, eff_e);
        chk(sl_l == fl_l + eff_l, "R5 older period", sl_l - fl_l, eff_l);
        chk(sk_e == !pol, "R6 compact sck at lead", int'(sk_e), int'(!pol));
        chk(sk_l == !pol, "R6 older sck at lead", int'(sk_l), int'(!pol));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R9: reset state with transfer requested and cpol high
        repeat (4) @(negedge clk);
        chk(!lead_e && !trail_e, "R9 compact strobes in reset", int'(lead_e | trail_e), 0);
        chk(!lead_l && !trail_l, "R9 older strobes in reset", int'(lead_l | trail_l), 0);
        chk(sck_e == 1'b1, "R9 compact sck in reset", int'(sck_e), 1);
        chk(sck_l == 1'b1, "R9 older sck in reset", int'(sck_l), 1);
        rst = 1'b0;
        xfer = 1'b0;
        cpol = 1'b0;

        // R1 / R2: decode table, transfer idle
        for (int v = 0; v < 16; v++) begin
            @(negedge clk);
            field = VEC[v][31:24];
            @(negedge clk);
            chk(div_e == VEC[v][22:12], "R1 compact divider", int'(div_e), int'(VEC[v][22:12]));
            chk(div_l == VEC[v][10:0], "R2 older divider", int'(div_l), int'(VEC[v][10:0]));
        end

        // R4 R5 R6 R8: edge timing
        run_timing(8'h13, 1'b0, 6, 6, "R4");
        run_timing(8'h05, 1'b0, 5, 4, "R4");
        run_timing(8'h05, 1'b1, 5, 4, "R4");
        run_timing(8'h01, 1'b0, 1, 4, "R8");
        run_timing(8'h1F, 1'b1, 30, 30, "R4");

        // R3: idle level follows cpol, no strobes
        @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            cpol = ~cpol;
            #1;
            chk(sck_e == cpol && sck_l == cpol, "R3 idle sck", int'(sck_e), int'(cpol));
            chk(!(lead_e || trail_e || lead_l || trail_l), "R3 idle strobes",
                int'(lead_e | trail_e | lead_l | trail_l), 0);
        end

        // R7: field change on the cycle the first edge is due
        @(negedge clk);
        cpol = 1'b0; field = 8'h13;
        repeat (3) @(negedge clk);
        xfer = 1'b1;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (i == 4 || i == 5)
                chk(!lead_e && !lead_l, "R7 edge suppressed by restart", int'(lead_e | lead_l), 0);
            if (i == 6) begin
                chk(lead_e, "R7 compact edge after new half", int'(lead_e), 1);
                chk(lead_l, "R7 older edge after new half", int'(lead_l), 1);
            end
            if (i == 3) field = 8'h12;
        end
        xfer = 1'b0;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule